// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Aggregator

This block holds the control/status word of every channel in a multi-channel DMA controller and merges the channels' interrupt sources into one summary word and a single interrupt line. Software writes a 32-bit word to one channel at a time. The channel engines report status events as single-cycle pulses, one bit per channel. The block stores sticky flags for each channel. These flags are cleared by writing a one, except for the stop flag, which changes as a side effect of run and mask writes. The block also captures the control bits and emits a one-cycle start pulse toward the engine when a run is requested. The start pulse tells the engine whether to begin with a descriptor fetch.

Each flag that has an enable bit raises an interrupt only when that enable bit is set. The start and end flags always raise an interrupt. The summary word holds one bit per channel, and the interrupt output is the OR of that word. All inputs and outputs are plain control/status pins. The block has no streaming data path, so no valid/ready handshake and no back-pressure apply.

Top module: `dma_stat_agg`

## Requirements
- R1: After reset every channel reads 0x0000_0008 (stop flag set, everything else clear), the summary is zero, the interrupt is low, and no start pulse is active.
- R2: A write stores bits 22, 23 and 26 to 31 of the written word as control bits. Any other written bit that has no command meaning in R3 to R6 has no effect on the readback.
- R3: Writing 1 to bit 0 (bus error), bit 1 (start), bit 2 (end) or bit 9 (end-of-receive) clears that flag. If an event for the same flag arrives in the same cycle, the event wins and the flag ends up set.
- R4: The compare status flag reads at bit 10. Writing 1 to bit 24 clears it and writing 1 to bit 25 sets it. If both bits are 1, the flag is set.
- R5: A write with bit 31 (run) set clears the stop flag (bit 3) and the request-after-stop flag (bit 4). In the following cycle it raises start_pulse for exactly one cycle, with start_fetch high unless bit 30 (no-descriptor-fetch) was written as 1.
- R6: A write with both bit 31 and bit 22 (mask-run) clear sets the stop flag. A write with only bit 22 set leaves the stop flag unchanged.
- R7: Three flags are gated by an enable bit. Stop is gated by bit 29, end-of-receive by bit 28, and request-after-stop by bit 23. The bus error flag never raises an interrupt.
- R8: The start and end flags raise an interrupt with no enable bit.
- R9: Bit c of int_summary is set exactly when channel c has an active interrupt source, and irq is the OR of all summary bits. Both are visible in the cycle after the edge that captured the event or write.
- R10: Bit 8 of a channel's readback follows that channel's req_active input combinationally.
- R11: The status event pulses set these flags: bus error at bit 0, start at bit 1, end at bit 2, stop at bit 3, request-after-stop at bit 4 and end-of-receive at bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | CHW | Channel addressed by the write |
| wr_data | input | 32 | Written control/status word |
| rd_ch | input | CHW | Channel selected for readback |
| rd_data | output | 32 | Control/status word of rd_ch |
| req_active | input | NCH | Peripheral request level per channel |
| ev_buserr | input | NCH | Bus error event pulses |
| ev_start | input | NCH | Descriptor start event pulses |
| ev_end | input | NCH | Transfer end event pulses |
| ev_stop | input | NCH | Channel stopped event pulses |
| ev_ras | input | NCH | Request-after-stop event pulses |
| ev_eor | input | NCH | End-of-receive event pulses |
| start_pulse | output | NCH | One-cycle run start per channel |
| start_fetch | output | NCH | Start begins with a descriptor fetch |
| int_summary | output | 32 | Per-channel interrupt summary |
| irq | output | 1 | Combined interrupt |

## Verification
Writes and events are registered once. The flags, rd_data, int_summary and irq therefore change one cycle after the stimulus. The bench applies each stimulus on a falling edge and samples at the next falling edge, half a cycle after the capturing rising edge. start_pulse and start_fetch are flops set by that same edge, so they are checked at that same falling edge and again one cycle later to confirm they have dropped. The request-pending bit has no register in its path, so it is sampled one nanosecond after req_active changes, with no clock edge in between.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;
  localparam int B_BUSERR  = 0;
  localparam int B_START   = 1;
  localparam int B_END     = 2;
  localparam int B_STOP    = 3;
  localparam int B_RAS     = 4;
  localparam int B_REQ     = 8;
  localparam int B_EOR     = 9;
  localparam int B_CMP     = 10;
  localparam int B_MASKRUN = 22;
  localparam int B_RASEN   = 23;
  localparam int B_CMPCLR  = 24;
  localparam int B_CMPSET  = 25;
  localparam int B_EOREN   = 28;
  localparam int B_STOPEN  = 29;
  localparam int B_NOFETCH = 30;
  localparam int B_RUN     = 31;
  localparam logic [31:0] CTRL_MASK = 32'hFCC0_0000;

  typedef struct packed {
    logic buserr;
    logic start;
    logic done;
    logic stop;
    logic ras;
    logic eor;
    logic cmp;
  } flags_t;

  localparam flags_t FLAGS_RST = '{buserr: 1'b0, start: 1'b0, done: 1'b0,
                                   stop: 1'b1, ras: 1'b0, eor: 1'b0, cmp: 1'b0};
endpackage

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
  import dma_stat_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] wr_data,
  input  logic        req,
  input  logic        ev_buserr,
  input  logic        ev_start,
  input  logic        ev_end,
  input  logic        ev_stop,
  input  logic        ev_ras,
  input  logic        ev_eor,
  output logic [31:0] csr,
  output logic        irq_src,
  output logic        start_pulse,
  output logic        start_fetch
);
  flags_t      fl_q, fl_d;
  logic [31:0] ctrl_q;

  always_comb begin
    fl_d = fl_q;
    if (wr) begin
      if (wr_data[B_BUSERR]) fl_d.buserr = 1'b0;
      if (wr_data[B_START])  fl_d.start  = 1'b0;
      if (wr_data[B_END])    fl_d.done   = 1'b0;
      if (wr_data[B_EOR])    fl_d.eor    = 1'b0;
      if (wr_data[B_RUN]) begin
        fl_d.stop = 1'b0;
        fl_d.ras  = 1'b0;
      end else if (!wr_data[B_MASKRUN]) begin
        fl_d.stop = 1'b1;
      end
      if (wr_data[B_CMPCLR]) fl_d.cmp = 1'b0;
      if (wr_data[B_CMPSET]) fl_d.cmp = 1'b1;
    end
    // events are applied last so they win over a same-cycle clear
    if (ev_buserr) fl_d.buserr = 1'b1;
    if (ev_start)  fl_d.start  = 1'b1;
    if (ev_end)    fl_d.done   = 1'b1;
    if (ev_stop)   fl_d.stop   = 1'b1;
    if (ev_ras)    fl_d.ras    = 1'b1;
    if (ev_eor)    fl_d.eor    = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fl_q        <= FLAGS_RST;
      ctrl_q      <= '0;
      start_pulse <= 1'b0;
      start_fetch <= 1'b0;
    end else begin
      fl_q        <= fl_d;
      if (wr) ctrl_q <= wr_data & CTRL_MASK;
      start_pulse <= wr & wr_data[B_RUN];
      start_fetch <= wr & wr_data[B_RUN] & ~wr_data[B_NOFETCH];
    end
  end

  always_comb begin
    csr           = ctrl_q;
    csr[B_BUSERR] = fl_q.buserr;
    csr[B_START]  = fl_q.start;
    csr[B_END]    = fl_q.done;
    csr[B_STOP]   = fl_q.stop;
    csr[B_RAS]    = fl_q.ras;
    csr[B_REQ]    = req;
    csr[B_EOR]    = fl_q.eor;
    csr[B_CMP]    = fl_q.cmp;
  end

  assign irq_src = (fl_q.stop & ctrl_q[B_STOPEN]) |
                   (fl_q.eor  & ctrl_q[B_EOREN])  |
                   (fl_q.ras  & ctrl_q[B_RASEN])  |
                   fl_q.start | fl_q.done;

  // R5
  run_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wr_data[B_RUN]) |=> start_pulse);
  // R6
  stop_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !wr_data[B_RUN] && !wr_data[B_MASKRUN]) |=> csr[B_STOP]);
  // R4
  cmp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wr_data[B_CMPSET]) |=> csr[B_CMP]);
  // R3
  start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wr_data[B_START] && !ev_start) |=> !csr[B_START]);
  // R8
  end_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end |=> irq_src);
endmodule

// File: rtl/dma_irq_sum.sv
module dma_irq_sum #(
  parameter int NCH = 8
) (
  input  logic [NCH-1:0] src,
  output logic [31:0]    summary,
  output logic           irq
);
  generate
    for (genvar c = 0; c < 32; c++) begin : g_bit
      if (c < NCH) begin : g_used
        assign summary[c] = src[c];
      end else begin : g_pad
        assign summary[c] = 1'b0;
      end
    end
  endgenerate

  assign irq = |src;
endmodule

// File: rtl/dma_stat_agg.sv
module dma_stat_agg #(
  parameter int NCH = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CHW-1:0]  wr_ch,
  input  logic [31:0]     wr_data,
  input  logic [CHW-1:0]  rd_ch,
  output logic [31:0]     rd_data,
  input  logic [NCH-1:0]  req_active,
  input  logic [NCH-1:0]  ev_buserr,
  input  logic [NCH-1:0]  ev_start,
  input  logic [NCH-1:0]  ev_end,
  input  logic [NCH-1:0]  ev_stop,
  input  logic [NCH-1:0]  ev_ras,
  input  logic [NCH-1:0]  ev_eor,
  output logic [NCH-1:0]  start_pulse,
  output logic [NCH-1:0]  start_fetch,
  output logic [31:0]     int_summary,
  output logic            irq
);
  logic [31:0]    csr_arr [NCH];
  logic [NCH-1:0] src;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      dma_chan_csr u_ch (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (wr_en && (int'(wr_ch) == c)),
        .wr_data     (wr_data),
        .req         (req_active[c]),
        .ev_buserr   (ev_buserr[c]),
        .ev_start    (ev_start[c]),
        .ev_end      (ev_end[c]),
        .ev_stop     (ev_stop[c]),
        .ev_ras      (ev_ras[c]),
        .ev_eor      (ev_eor[c]),
        .csr         (csr_arr[c]),
        .irq_src     (src[c]),
        .start_pulse (start_pulse[c]),
        .start_fetch (start_fetch[c])
      );
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NCH; c++)
      if (int'(rd_ch) == c) rd_data = csr_arr[c];
  end

  dma_irq_sum #(.NCH(NCH)) u_sum (
    .src     (src),
    .summary (int_summary),
    .irq     (irq)
  );

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start != '0) |=> irq);
endmodule

// File: tb/dma_stat_agg_tb_top.sv
module dma_stat_agg_tb_top;
  localparam int NCH = 4;
  localparam int CHW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [CHW-1:0] wr_ch = '0, rd_ch = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, int_summary;
  logic [NCH-1:0] req_active = '0, ev_buserr = '0, ev_start = '0, ev_end = '0;
  logic [NCH-1:0] ev_stop = '0, ev_ras = '0, ev_eor = '0;
  logic [NCH-1:0] start_pulse, start_fetch;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dma_stat_agg #(.NCH(NCH)) dut_i (.*);

  // {exp_irq, write data, expected readback} applied to channel 1
  localparam logic [64:0] VEC [9] = '{
    {1'b0, 32'h0000_0000, 32'h0000_0008},  // R6
    {1'b1, 32'h2000_0000, 32'h2000_0008},  // R7 stop gated on
    {1'b0, 32'h8000_0000, 32'h8000_0000},  // R5
    {1'b0, 32'h0040_0000, 32'h0040_0000},  // R6 mask keeps stop
    {1'b0, 32'h0100_0000, 32'h0000_0008},  // R4 clear
    {1'b0, 32'h0200_0000, 32'h0000_0408},  // R4 set
    {1'b0, 32'h0300_0000, 32'h0000_0408},  // R4 set wins
    {1'b0, 32'h0140_0000, 32'h0040_0008},  // R4 clear, R6
    {1'b0, 32'h0000_F1E0, 32'h0000_0008}   // R2 other bits ignored
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input logic [31:0] d, input logic [NCH-1:0] st = '0);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = CHW'(ch); wr_data = d; ev_start = st;
    @(negedge clk);
    wr_en = 1'b0; ev_start = '0; rd_ch = CHW'(ch);
    #1;
  endtask

  task automatic ev(input int ch, input int kind);
    @(negedge clk);
    case (kind)
      0: ev_buserr[ch] = 1'b1;
      1: ev_start[ch]  = 1'b1;
      2: ev_end[ch]    = 1'b1;
      3: ev_stop[ch]   = 1'b1;
      4: ev_ras[ch]    = 1'b1;
      default: ev_eor[ch] = 1'b1;
    endcase
    @(negedge clk);
    ev_buserr = '0; ev_start = '0; ev_end = '0; ev_stop = '0; ev_ras = '0; ev_eor = '0;
    rd_ch = CHW'(ch);
    #1;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      rd_ch = CHW'(c); #1;
      chk("R1 reset csr", rd_data, 32'h0000_0008);
    end
    chk("R1 summary", int_summary, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 pulse", {28'b0, start_pulse}, 32'h0);

    for (int i = 0; i < 9; i++) begin
      wr(1, VEC[i][63:32]);
      chk("R2/R4/R5/R6 csr", rd_data, VEC[i][31:0]);
      chk("R7/R9 irq", {31'b0, irq}, {31'b0, VEC[i][64]});
      chk("R9 summary", int_summary, {30'b0, VEC[i][64], 1'b0});
    end

    ev(2, 1);
    chk("R11 start flag", rd_data, 32'h0000_000A);
    chk("R8 start irq", int_summary, 32'h4);
    wr(2, 32'h0040_0002);
    chk("R3 start clear", rd_data, 32'h0040_0008);
    chk("R3 irq drop", {31'b0, irq}, 32'h0);
    ev(2, 2);
    chk("R11 end flag", rd_data, 32'h0040_000C);
    chk("R8 end irq", {31'b0, irq}, 32'h1);
    wr(2, 32'h0040_0004);
    chk("R3 end clear", rd_data, 32'h0040_0008);
    ev(2, 5);
    chk("R11 eor flag", rd_data, 32'h0040_0208);
    chk("R7 eor ungated", {31'b0, irq}, 32'h0);
    wr(2, 32'h1040_0000);
    chk("R7 eor enabled", {31'b0, irq}, 32'h1);
    wr(2, 32'h1040_0200);
    chk("R3 eor clear", rd_data, 32'h1040_0008);
    ev(2, 4);
    chk("R11 ras flag", rd_data, 32'h1040_0018);
    chk("R7 ras ungated", {31'b0, irq}, 32'h0);
    wr(2, 32'h00C0_0000);
    chk("R7 ras enabled", int_summary, 32'h4);
    wr(2, 32'h8000_0000);
    chk("R5 run clears stop ras", rd_data, 32'h8000_0000);
    ev(2, 0);
    chk("R11 buserr flag", rd_data, 32'h8000_0001);
    chk("R7 buserr no irq", {31'b0, irq}, 32'h0);
    wr(2, 32'h8000_0001);
    chk("R3 buserr clear", rd_data, 32'h8000_0000);
    wr(2, 32'hA000_0000);
    ev(2, 3);
    chk("R11 stop flag", rd_data, 32'hA000_0008);
    chk("R7 stop irq", int_summary, 32'h4);
    wr(2, 32'hA000_0002, 4'b0100);
    chk("R3 event wins", rd_data, 32'hA000_0002);
    chk("R5 pulse fetch", {24'b0, start_pulse, start_fetch}, 32'h44);

    req_active[3] = 1'b1; rd_ch = 2'd3; #1;
    chk("R10 reqpend on", rd_data, 32'h0000_0108);
    req_active[3] = 1'b0; #1;
    chk("R10 reqpend off", rd_data, 32'h0000_0008);

    wr(3, 32'hC000_0000);
    chk("R5 nofetch pulse", {24'b0, start_pulse, start_fetch}, 32'h80);
    @(negedge clk); #1;
    chk("R5 pulse one cycle", {28'b0, start_pulse}, 32'h0);
    chk("R9 irq held", {31'b0, irq}, 32'h1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule